// File: doc/BRIEF.md
# Start/Done Transaction Handshake Controller

This block wraps a fixed-latency, non-pipelined compute core and gives it a block-level start/done handshake. A requester raises `startIn`. The block takes the operands in that same cycle and runs the core for a set number of cycles. It then raises `doneOut` and `readyOut` together for exactly one cycle, and the sum is presented on `resultOut` during that cycle only.

The level of `startIn` in the ready cycle decides what happens next. If it is high, the next transaction begins in that cycle, so transactions follow one another with no idle gap. If it is low, the block halts and reports idle one cycle later. The core used here adds the two captured operands and keeps the carry. Its latency is a parameter of at least two cycles.

Top module: `xact_handshake`

## Requirements
- R1: Reset is synchronous and active high. While reset is applied and in the first cycle after it, with `startIn` low, `idleOut` is 1, and `readyOut`, `doneOut` and `resultOut` are 0.
- R2: While no transaction is running and `startIn` stays low, `idleOut` stays 1 and `doneOut` stays 0.
- R3: `idleOut` goes to 0 in the same cycle that `startIn` is high while the block is idle. It stays 0 in every cycle of a transaction, up to and including the done cycle.
- R4: Call the cycle in which a transaction starts cycle 0. `doneOut` and `readyOut` are both 1 in cycle LATENCY only, as a single-cycle pulse. Neither is ever 1 unless a transaction is running.
- R5: In the done cycle, `resultOut` equals the zero-extended sum opA + opB, DATA_W+1 bits wide with the carry in the top bit, of the operands present in cycle 0. In every other cycle, `resultOut` is 0.
- R6: Changes on `opA` and `opB` after cycle 0 have no effect on the result of the transaction in flight.
- R7: If `startIn` is low in the done cycle, the block halts. `idleOut` is 1 in the next cycle if `startIn` is low in that cycle.
- R8: If `startIn` is high in the done cycle, that cycle is cycle 0 of a new transaction. Its operands are taken in that cycle, `idleOut` stays 0, and the next done follows LATENCY cycles later.
- R9: The level of `startIn` in the cycles of a transaction other than cycle 0 and the done cycle has no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Transaction request |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| idleOut | output | 1 | High while no transaction is running and none is being requested |
| readyOut | output | 1 | Pulses when a new request can be taken (same cycle as done) |
| doneOut | output | 1 | Pulses when the result is valid |
| resultOut | output | DATA_W+1 | Sum of the captured operands, nonzero only in the done cycle |

## Verification
Directed sequences are used for specific cases:
- a request held high only until ready, which separates halting from chaining;
- a request held high across several transactions, which exposes any gap or off-by-one in chained timing;
- operands that change right after the start cycle, which shows whether the operands are captured or read live;
- a request dropped in the middle of a transaction, which shows whether the core aborts;
- all-ones operands, which test the carry bit.

A long run with random request levels and random operands then mixes halts, restarts and chains at random points. A cycle-by-cycle bench model of the requirements is compared with every output in every cycle.

// File: rtl/xact_hs_pkg.sv
`timescale 1ns/1ps
package xact_hs_pkg;
  // Strobes issued by the control FSM to the datapath each cycle
  typedef struct packed {
    logic capture;  // take the operands into holding registers
    logic calc;     // update the sum register from the held operands
    logic present;  // drive the sum onto the result port
  } hsStrobes_t;
endpackage

// File: rtl/xact_hs_ctrl.sv
`timescale 1ns/1ps
module xact_hs_ctrl
  import xact_hs_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startIn,
  output hsStrobes_t strobes,
  output logic       idleOut,
  output logic       doneOut
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] FIRST_CNT = CNT_W'(1);

  typedef enum logic {ST_IDLE, ST_BUSY} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] cycleCnt;
  logic finishing;
  logic launch;

  assign finishing = (state == ST_BUSY) && (cycleCnt == LAST_CNT);
  // Requests are taken only while idle or in the ready cycle
  assign launch = startIn && ((state == ST_IDLE) || finishing);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cycleCnt <= '0;
    end else if (launch) begin
      state    <= ST_BUSY;
      cycleCnt <= FIRST_CNT;
    end else if (finishing) begin
      state    <= ST_IDLE;
      cycleCnt <= '0;
    end else if (state == ST_BUSY) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.capture = launch;
    strobes.calc    = (state == ST_BUSY) && (cycleCnt == FIRST_CNT);
    strobes.present = finishing;
  end

  // Idle falls in the very cycle a request appears
  assign idleOut = (state == ST_IDLE) && !startIn;
  assign doneOut = finishing;
endmodule

// File: rtl/xact_hs_dp.sv
`timescale 1ns/1ps
module xact_hs_dp
  import xact_hs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  hsStrobes_t        strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W:0]   resultOut
);
  localparam int RES_W = DATA_W + 1;

  logic [DATA_W-1:0] heldA;
  logic [DATA_W-1:0] heldB;
  logic [RES_W-1:0]  sumReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldA <= '0;
      heldB <= '0;
    end else if (strobes.capture) begin
      heldA <= opA;
      heldB <= opB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
    end else if (strobes.calc) begin
      sumReg <= {1'b0, heldA} + {1'b0, heldB};
    end
  end

  assign resultOut = strobes.present ? sumReg : '0;
endmodule

// File: rtl/xact_handshake.sv
`timescale 1ns/1ps
module xact_handshake
  import xact_hs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              idleOut,
  output logic              readyOut,
  output logic              doneOut,
  output logic [DATA_W:0]   resultOut
);
  hsStrobes_t strobes;

  xact_hs_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .startIn (startIn),
    .strobes (strobes),
    .idleOut (idleOut),
    .doneOut (doneOut)
  );

  xact_hs_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .resultOut (resultOut)
  );

  // Non-pipelined core: the next request can be taken when the current one ends
  assign readyOut = doneOut;
endmodule

// File: rtl/xact_handshake_chk.sv
`timescale 1ns/1ps
module xact_handshake_chk #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            startIn,
  input logic            idleOut,
  input logic            readyOut,
  input logic            doneOut,
  input logic [DATA_W:0] resultOut
);
  localparam int CW = $clog2(LATENCY + 1);

  // Independent tracker of the transaction window
  logic          chkBusy;
  logic [CW-1:0] chkCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      chkBusy <= 1'b0;
      chkCnt  <= '0;
    end else if (startIn && (!chkBusy || doneOut)) begin
      chkBusy <= 1'b1;
      chkCnt  <= CW'(1);
    end else if (doneOut) begin
      chkBusy <= 1'b0;
    end else if (chkBusy) begin
      chkCnt <= chkCnt + 1'b1;
    end
  end

  a_r3_idle_low_on_start: assert property (@(posedge clk) disable iff (rst)
    startIn |-> !idleOut);

  a_r4_done_on_time: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> (chkBusy && chkCnt == CW'(LATENCY)));

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);

  a_r4_ready_not_idle: assert property (@(posedge clk) disable iff (rst)
    readyOut |-> !idleOut);

  a_r5_result_quiet: assert property (@(posedge clk) disable iff (rst)
    !doneOut |-> (resultOut == '0));

  a_r7_idle_after_halt: assert property (@(posedge clk) disable iff (rst)
    (doneOut && !startIn) |=> (idleOut != startIn));

  a_r8_chain_no_idle: assert property (@(posedge clk) disable iff (rst)
    (doneOut && startIn) |=> !idleOut);

  a_r2_no_done_from_idle: assert property (@(posedge clk) disable iff (rst)
    idleOut |=> !doneOut);
endmodule

bind xact_handshake xact_handshake_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .startIn   (startIn),
  .idleOut   (idleOut),
  .readyOut  (readyOut),
  .doneOut   (doneOut),
  .resultOut (resultOut)
);

// File: tb/tb_xact_handshake.sv
`timescale 1ns/1ps
module tb_xact_handshake;
  localparam int W = 16;
  localparam int L = 4;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startIn = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic idleOut, readyOut, doneOut;
  logic [W:0] resultOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Requirement model state
  logic mBusy = 1'b0;
  int   mCnt = 0;
  logic [W:0] mSum = '0;

  xact_handshake #(.DATA_W(W), .LATENCY(L)) dut (
    .clk(clk), .rst(rst), .startIn(startIn), .opA(opA), .opB(opB),
    .idleOut(idleOut), .readyOut(readyOut), .doneOut(doneOut),
    .resultOut(resultOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [W:0] refSum(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One clock cycle: drive, compare against the model, advance the model
  task automatic cyc(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                     input string tag);
    logic expDone;
    logic expIdle;
    @(negedge clk);
    startIn = s; opA = a; opB = b;
    #2;
    expDone = mBusy && (mCnt == L);
    expIdle = !mBusy && !s;
    chk(tag, "idle R3", 32'(idleOut), 32'(expIdle));
    chk(tag, "done R4", 32'(doneOut), 32'(expDone));
    chk(tag, "ready R4", 32'(readyOut), 32'(expDone));
    chk(tag, "result R5", 32'(resultOut), expDone ? 32'(mSum) : 32'd0);
    if (s && (!mBusy || expDone)) begin
      mBusy = 1'b1; mCnt = 1; mSum = refSum(a, b);
    end else if (expDone) begin
      mBusy = 1'b0;
    end else if (mBusy) begin
      mCnt++;
    end
  endtask

  task automatic rnd(output logic [W-1:0] v);
    v = W'($urandom);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES) begin
        checks++; errors++;
        $display("FAIL R4 watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
        summary();
      end
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    int seedInit;
    seedInit = $urandom(32'd5171);
    // R1: reset state
    repeat (2) begin
      @(negedge clk); #2;
      chk("R1", "idle in reset", 32'(idleOut), 32'd1);
      chk("R1", "done in reset", 32'(doneOut), 32'd0);
      chk("R1", "ready in reset", 32'(readyOut), 32'd0);
      chk("R1", "result in reset", 32'(resultOut), 32'd0);
    end
    @(negedge clk); rst = 1'b0;
    cyc(1'b0, 16'h0, 16'h0, "R1");

    // R2: nothing happens without a request
    for (int i = 0; i < 6; i++) cyc(1'b0, 16'h1234, 16'h4321, "R2");

    // R7: request held to ready, then dropped -> halt, idle next cycle
    cyc(1'b1, 16'd100, 16'd23, "R7");
    for (int i = 1; i < L; i++) cyc(1'b1, 16'd100, 16'd23, "R7");
    cyc(1'b0, 16'd0, 16'd0, "R7");   // done cycle
    cyc(1'b0, 16'd0, 16'd0, "R7");   // idle rises here
    chk("R7", "idle after halt", 32'(idleOut), 32'd1);

    // R6: operands change right after the start cycle
    cyc(1'b1, 16'h0F0F, 16'h0101, "R6");
    for (int i = 1; i < L; i++) cyc(1'b1, 16'hAAAA + 16'(i), 16'h5555, "R6");
    cyc(1'b0, 16'hFFFF, 16'hFFFF, "R6");
    chk("R6", "model idle", 32'(mBusy), 32'd0);
    cyc(1'b0, 16'h0, 16'h0, "R6");

    // R8: request held high across several back-to-back transactions
    for (int i = 0; i < 4 * L; i++) cyc(1'b1, 16'(i * 97), 16'(i * 13 + 1), "R8");
    cyc(1'b0, 16'h0, 16'h0, "R8");
    while (mBusy) cyc(1'b0, 16'h0, 16'h0, "R8");

    // R5 boundary: carry out of all-ones operands
    cyc(1'b1, 16'hFFFF, 16'hFFFF, "R5");
    for (int i = 1; i < L; i++) cyc(1'b1, 16'h0, 16'h0, "R5");
    @(negedge clk); startIn = 1'b0; #2;
    chk("R5", "carry sum", 32'(resultOut), 32'h1FFFE);
    mBusy = 1'b0;
    cyc(1'b0, 16'h0, 16'h0, "R5");

    // R9: request dropped mid-transaction does not abort
    cyc(1'b1, 16'd7, 16'd8, "R9");
    for (int i = 1; i < L; i++) cyc(1'b0, 16'd1, 16'd1, "R9");
    cyc(1'b0, 16'd0, 16'd0, "R9");
    cyc(1'b0, 16'd0, 16'd0, "R9");

    // Random mix of halts, restarts and chains
    for (int i = 0; i < 3000; i++) begin
      rnd(ra); rnd(rb);
      cyc(($urandom % 4) != 0, ra, rb, "R8");
    end
    summary();
  end
endmodule